// File: doc/BRIEF.md
# Low-Power Compare/Period Timer

This block is a 16-bit up-counting timer with a simple word-addressed register bus. Software sets a period value and a compare value, then starts the counter. The counter runs once (one-shot) or repeats (continuous). The count rate comes from the system clock through a power-of-two prescaler. Crossing the compare value and reaching the period end each raise a sticky status flag. A waveform pin is driven either as a PWM signal or as a level that is set once, and a polarity bit can invert it.

Instead of starting at once, a start command can arm the counter so that it waits for an external trigger pin. The trigger can be taken on its rising edge, its falling edge or either edge. A configurable digital filter rejects pulses shorter than the selected number of samples. Compare and period writes can go straight into effect, or they can be held in a shadow register until the current period ends. Each kind of write raises its own completion flag. All flags are cleared by writing ones. An enable mask gates the flags onto a single interrupt line.

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped at 0, and `irq` and `wave_out` are low.
- R2: The registers sit at these byte offsets: flags 0x00, flag clear 0x04, interrupt mask 0x08, setup 0x0C, run control 0x10, compare 0x14, period 0x18, count 0x1C. The count register is read-only. In run control, the two start bits (bit1 and bit2) read back as 0.
- R3: Setup bits 11:9 hold a prescaler code k. While running, the counter advances once every 2^k clocks, so N clocks after a start it reads floor(N/2^k) mod (period+1).
- R4: On an advance taken while the counter equals the period value, the counter returns to 0 and flag bit1 is set.
- R5: On an advance taken while the counter equals the compare value, flag bit0 is set.
- R6: A start with run-control bit1 (one-shot) stops the counter at 0 after its first wrap. A start with bit2 (continuous) keeps it running.
- R7: Writing run control with bit0 = 0 stops the counter and clears it to 0. A start is accepted only when the same write has bit0 = 1.
- R8: With setup bit20 = 0 (PWM shape), the raw waveform is high exactly while count > compare (for compare <= period). Setup bit21 inverts `wave_out`.
- R9: With setup bit20 = 1 (set-once shape), the waveform stays high after a wrap. It goes low again only on the next start or on disable.
- R10: Setup bits 18:17 select the start source: 0 means software only, 1 the rising edge, 2 the falling edge, 3 both edges. When the field is nonzero, a start command only arms the counter. An accepted edge then starts it in the last requested mode and sets flag bit2.
- R11: Setup bits 7:6 give a filter code f. A trigger level change is accepted only after 2^f consecutive equal samples (code 0 means no filter), so shorter pulses are ignored.
- R12: A compare or period write sets flag bit3 or bit4 one clock after the new value is in effect. Without preload (setup bit22 = 0), or while the counter is stopped, the value takes effect one clock after the write. With preload on and the counter running, it takes effect at the next wrap.
- R13: Writing ones to the clear offset clears the matching flag bits and leaves the others alone. A flag being set in the same clock wins over the clear.
- R14: `irq` is high while any flag bit is set together with its bit in the interrupt mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| trig_in | input | 1 | External trigger pin |
| wave_out | output | 1 | Waveform output |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that software does not issue a start command in the same clock as a wrap in one-shot mode, and that the trigger pin is low when reset is released. The stimulus keeps to both rules. It reconfigures the timer only while it is disabled, and it drives the trigger only while the timer is armed and waiting. Random runs draw compare values no larger than the period, because the waveform rule is stated for that range.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int PSC_W  = 3;
    localparam int FLT_W  = 2;
    localparam int FLAG_N = 5;

    // register byte offsets
    localparam logic [7:0] OFS_FLAGS = 8'h00;
    localparam logic [7:0] OFS_CLR   = 8'h04;
    localparam logic [7:0] OFS_MASK  = 8'h08;
    localparam logic [7:0] OFS_SETUP = 8'h0C;
    localparam logic [7:0] OFS_RUN   = 8'h10;
    localparam logic [7:0] OFS_CMP   = 8'h14;
    localparam logic [7:0] OFS_PER   = 8'h18;
    localparam logic [7:0] OFS_CNT   = 8'h1C;

    // flag bit positions
    localparam int FLG_CMP   = 0;
    localparam int FLG_WRAP  = 1;
    localparam int FLG_TRIG  = 2;
    localparam int FLG_CMPWR = 3;
    localparam int FLG_PERWR = 4;

    typedef enum logic [1:0] {
        TRG_SOFT = 2'd0,
        TRG_RISE = 2'd1,
        TRG_FALL = 2'd2,
        TRG_BOTH = 2'd3
    } trg_mode_e;

    typedef struct packed {
        logic             preload;
        logic             invert;
        logic             once;
        trg_mode_e        tmode;
        logic [PSC_W-1:0] psc;
        logic [FLT_W-1:0] flt;
    } setup_t;

    function automatic setup_t setup_unpack(input logic [DATA_W-1:0] w);
        setup_t s;
        s.flt     = w[7:6];
        s.psc     = w[11:9];
        s.tmode   = trg_mode_e'(w[18:17]);
        s.once    = w[20];
        s.invert  = w[21];
        s.preload = w[22];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] setup_pack(input setup_t s);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[7:6]   = s.flt;
        w[11:9]  = s.psc;
        w[18:17] = s.tmode;
        w[20]    = s.once;
        w[21]    = s.invert;
        w[22]    = s.preload;
        return w;
    endfunction

    // low-bit mask: code k gives k ones
    function automatic logic [(1<<PSC_W)-2:0] div_mask(input logic [PSC_W-1:0] code);
        logic [(1<<PSC_W)-2:0] m;
        for (int i = 0; i < (1<<PSC_W)-1; i++) m[i] = (i < int'(code));
        return m;
    endfunction

    function automatic logic edge_selected(input trg_mode_e m, input logic rise, input logic fall);
        case (m)
            TRG_RISE: return rise;
            TRG_FALL: return fall;
            TRG_BOTH: return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ltmr_trig_filt.sv
module ltmr_trig_filt
    import ltmr_pkg::*;
#(
    parameter int SYNC_N = 2,
    parameter int FW     = FLT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin,
    input  logic [FW-1:0] flt_code,
    output logic          rise,
    output logic          fall
);
    localparam int MAX_LOG = (1 << FW) - 1;
    localparam int RUN_W   = MAX_LOG + 1;

    logic [SYNC_N-1:0] sync_q;
    logic              level_q;
    logic [RUN_W-1:0]  run_q;
    logic [RUN_W-1:0]  run_nxt;
    logic [RUN_W-1:0]  need;
    logic              samp;

    genvar g;
    generate
        for (g = 0; g < SYNC_N; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign samp    = sync_q[SYNC_N-1];
    assign run_nxt = run_q + RUN_W'(1);
    assign need    = RUN_W'(1) << flt_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            run_q   <= '0;
            rise    <= 1'b0;
            fall    <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (samp == level_q) begin
                run_q <= '0;
            end else if (run_nxt >= need) begin
                level_q <= samp;
                run_q   <= '0;
                rise    <= samp;
                fall    <= ~samp;
            end else begin
                run_q <= run_nxt;
            end
        end
    end
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core
    import ltmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PSC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sw_start,
    input  logic          sw_cont,
    input  logic          ext_src,
    input  logic          ext_hit,
    input  logic [PW-1:0] psc,
    input  logic          once,
    input  logic [CW-1:0] cmp_val,
    input  logic [CW-1:0] per_val,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          mode_cont,
    output logic          cmp_evt,
    output logic          wrap_evt,
    output logic          wave_raw
);
    localparam int DW = (1 << PW) - 1;

    logic [DW-1:0] pcnt_q;
    logic [DW-1:0] mask;
    logic          armed_q;
    logic          tick;
    logic          go;

    assign mask     = div_mask(psc);
    assign tick     = running && ((pcnt_q & mask) == mask);
    assign cmp_evt  = tick && (cnt == cmp_val);
    assign wrap_evt = tick && (cnt == per_val);
    assign go       = (sw_start && !ext_src) ||
                      (en && armed_q && ext_src && ext_hit && !running);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt       <= '0;
            running   <= 1'b0;
            mode_cont <= 1'b0;
            pcnt_q    <= '0;
            armed_q   <= 1'b0;
            wave_raw  <= 1'b0;
        end else begin
            if (sw_start) begin
                mode_cont <= sw_cont;
                if (ext_src) armed_q <= 1'b1;
            end
            if (go) begin
                running  <= 1'b1;
                cnt      <= '0;
                pcnt_q   <= '0;
                wave_raw <= 1'b0;
            end else if (running) begin
                pcnt_q <= pcnt_q + DW'(1);
                if (tick) begin
                    if (wrap_evt) begin
                        cnt <= '0;
                        if (!mode_cont) running <= 1'b0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                    if (wrap_evt && !once) wave_raw <= 1'b0;
                    else if (cmp_evt)      wave_raw <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lp_cmp_timer.sv
module lp_cmp_timer
    import ltmr_pkg::*;
#(
    parameter int CW     = CNT_W,
    parameter int AW     = ADDR_W,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig_in,
    output logic              wave_out,
    output logic              irq
);
    setup_t            setup_q;
    logic              en_q;
    logic              en_nxt;
    logic [FLAG_N-1:0] mask_q;
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] clr_vec;
    logic [CW-1:0]     cmp_act, per_act, cmp_buf, per_buf;
    logic              cmp_pend, per_pend, cmp_done_q, per_done_q;
    logic              cmp_apply, per_apply;
    logic              sw_start;
    logic              t_rise, t_fall, ext_hit;
    logic [CW-1:0]     cnt_w;
    logic              running_w, mode_cont_w, cmp_evt_w, wrap_evt_w, wave_raw_w;

    logic wr_run, wr_setup, wr_mask, wr_clr, wr_cmp, wr_per;
    assign wr_run   = bus_wr && (bus_addr == AW'(OFS_RUN));
    assign wr_setup = bus_wr && (bus_addr == AW'(OFS_SETUP));
    assign wr_mask  = bus_wr && (bus_addr == AW'(OFS_MASK));
    assign wr_clr   = bus_wr && (bus_addr == AW'(OFS_CLR));
    assign wr_cmp   = bus_wr && (bus_addr == AW'(OFS_CMP));
    assign wr_per   = bus_wr && (bus_addr == AW'(OFS_PER));

    assign en_nxt   = wr_run ? bus_wdata[0] : en_q;
    assign sw_start = wr_run && bus_wdata[0] && (bus_wdata[1] || bus_wdata[2]);

    ltmr_trig_filt #(.SYNC_N(SYNC_N), .FW(FLT_W)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .pin      (trig_in),
        .flt_code (setup_q.flt),
        .rise     (t_rise),
        .fall     (t_fall)
    );

    assign ext_hit = edge_selected(setup_q.tmode, t_rise, t_fall);

    ltmr_core #(.CW(CW), .PW(PSC_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .en        (en_nxt),
        .sw_start  (sw_start),
        .sw_cont   (bus_wdata[2]),
        .ext_src   (setup_q.tmode != TRG_SOFT),
        .ext_hit   (ext_hit),
        .psc       (setup_q.psc),
        .once      (setup_q.once),
        .cmp_val   (cmp_act),
        .per_val   (per_act),
        .cnt       (cnt_w),
        .running   (running_w),
        .mode_cont (mode_cont_w),
        .cmp_evt   (cmp_evt_w),
        .wrap_evt  (wrap_evt_w),
        .wave_raw  (wave_raw_w)
    );

    assign cmp_apply = cmp_pend && (!setup_q.preload || !running_w || wrap_evt_w);
    assign per_apply = per_pend && (!setup_q.preload || !running_w || wrap_evt_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            setup_q    <= '0;
            mask_q     <= '0;
            cmp_act    <= '0;
            per_act    <= '0;
            cmp_buf    <= '0;
            per_buf    <= '0;
            cmp_pend   <= 1'b0;
            per_pend   <= 1'b0;
            cmp_done_q <= 1'b0;
            per_done_q <= 1'b0;
        end else begin
            en_q       <= en_nxt;
            cmp_done_q <= cmp_apply;
            per_done_q <= per_apply;
            if (wr_setup) setup_q <= setup_unpack(bus_wdata);
            if (wr_mask)  mask_q  <= bus_wdata[FLAG_N-1:0];
            if (cmp_apply) begin
                cmp_act  <= cmp_buf;
                cmp_pend <= 1'b0;
            end
            if (per_apply) begin
                per_act  <= per_buf;
                per_pend <= 1'b0;
            end
            if (wr_cmp) begin
                cmp_buf  <= bus_wdata[CW-1:0];
                cmp_pend <= 1'b1;
            end
            if (wr_per) begin
                per_buf  <= bus_wdata[CW-1:0];
                per_pend <= 1'b1;
            end
        end
    end

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_CMP]   = cmp_evt_w;
        set_vec[FLG_WRAP]  = wrap_evt_w;
        set_vec[FLG_TRIG]  = ext_hit;
        set_vec[FLG_CMPWR] = cmp_done_q;
        set_vec[FLG_PERWR] = per_done_q;
        clr_vec            = wr_clr ? bus_wdata[FLAG_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    assign irq      = |(flags_q & mask_q);
    assign wave_out = wave_raw_w ^ setup_q.invert;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                AW'(OFS_FLAGS): bus_rdata = DATA_W'(flags_q);
                AW'(OFS_MASK):  bus_rdata = DATA_W'(mask_q);
                AW'(OFS_SETUP): bus_rdata = setup_pack(setup_q);
                AW'(OFS_RUN):   bus_rdata = DATA_W'(en_q);
                AW'(OFS_CMP):   bus_rdata = DATA_W'(cmp_act);
                AW'(OFS_PER):   bus_rdata = DATA_W'(per_act);
                AW'(OFS_CNT):   bus_rdata = DATA_W'(cnt_w);
                default:        bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ltmr_chk.sv
module ltmr_chk
    import ltmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CW-1:0]     cnt_w,
    input logic              running_w,
    input logic              en_nxt,
    input logic              mode_cont_w,
    input logic              cmp_evt_w,
    input logic              wrap_evt_w,
    input logic              wave_raw_w,
    input logic [FLAG_N-1:0] flags_q
);
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_w != $past(cnt_w)) |-> (cnt_w == $past(cnt_w) + CW'(1) || cnt_w == '0));

    // R6
    stop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(running_w) |-> (!$past(en_nxt) || ($past(wrap_evt_w) && !$past(mode_cont_w))));

    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[FLG_WRAP]) |-> $past(wrap_evt_w));

    // R5
    cmp_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[FLG_CMP]) |-> $past(cmp_evt_w));

    // R8
    wave_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wave_raw_w) |-> $past(cmp_evt_w));

    // R13
    clr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'(OFS_CLR) && bus_wdata[FLG_WRAP] && !wrap_evt_w)
            |=> !flags_q[FLG_WRAP]);

    // R7
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en_nxt |=> (cnt_w == '0 && !running_w));
endmodule

bind lp_cmp_timer ltmr_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .cnt_w       (cnt_w),
    .running_w   (running_w),
    .en_nxt      (en_nxt),
    .mode_cont_w (mode_cont_w),
    .cmp_evt_w   (cmp_evt_w),
    .wrap_evt_w  (wrap_evt_w),
    .wave_raw_w  (wave_raw_w),
    .flags_q     (flags_q)
);

// File: tb/lp_cmp_timer_tb.sv
module lp_cmp_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trig_in = 1'b0;
    logic        wave_out;
    logic        irq;

    int checks = 0;
    int errors = 0;

    lp_cmp_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .trig_in   (trig_in),
        .wave_out  (wave_out),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk_setup(int psc, int flt, int tmode, int once, int inv, int pre);
        return (32'(psc) << 9) | (32'(flt) << 6) | (32'(tmode) << 17) |
               (32'(once) << 20) | (32'(inv) << 21) | (32'(pre) << 22);
    endfunction

    function automatic int exp_cnt(int n, int d, int per);
        return (n / d) % (per + 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setup_off(input logic [31:0] s, input int cmp, input int per);
        wr(8'h10, 32'h0);
        wr(8'h0C, s);
        wr(8'h14, 32'(cmp));
        wr(8'h18, 32'(per));
        idle(3);
        wr(8'h04, 32'h1F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, v); check("R1 flags", v, 0);
        rd(8'h1C, v); check("R1 count", v, 0);
        rd(8'h0C, v); check("R1 setup", v, 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 wave", 32'(wave_out), 0);

        // R2 count is read-only, setup readback
        wr(8'h1C, 32'h1234);
        rd(8'h1C, v); check("R2 count ro", v, 0);
        wr(8'h0C, mk_setup(5, 2, 1, 1, 0, 1));
        rd(8'h0C, v); check("R2 setup readback", v, mk_setup(5, 2, 1, 1, 0, 1));

        // R12 write-done timing without preload
        setup_off(mk_setup(0, 0, 0, 0, 0, 0), 0, 0);
        wr(8'h14, 32'd7);
        idle(1);
        rd(8'h00, v); check("R12 cmp done early", v[3], 0);
        idle(1);
        rd(8'h00, v); check("R12 cmp done", v[3], 1);
        rd(8'h14, v); check("R12 cmp value", v, 7);

        // R3 R4 R5 R8 random continuous runs
        for (int it = 0; it < 10; it++) begin
            int psc, per, cmp, inv, n, d, c;
            psc = int'($urandom_range(0, 4));
            per = int'($urandom_range(2, 15));
            cmp = int'($urandom_range(0, per));
            inv = int'($urandom_range(0, 1));
            n   = int'($urandom_range(0, 150));
            d   = 1 << psc;
            setup_off(mk_setup(psc, 0, 0, 0, inv, 0), cmp, per);
            wr(8'h10, 32'h5);
            idle(n);
            rd(8'h1C, v);
            c = exp_cnt(n, d, per);
            check("R3 count", v, 32'(c));
            check("R8 wave", 32'(wave_out), 32'((c > cmp) ^ (inv != 0)));
            rd(8'h00, v);
            check("R4 wrap flag", v[1], 32'((n / d) >= per + 1));
            check("R5 cmp flag", v[0], 32'((n / d) >= cmp + 1));
        end

        // R2 start bits read 0
        rd(8'h10, v); check("R2 run readback", v, 1);

        // R3 largest prescaler
        setup_off(mk_setup(7, 0, 0, 0, 0, 0), 0, 1000);
        wr(8'h10, 32'h5);
        idle(300);
        rd(8'h1C, v); check("R3 div128", v, 2);

        // R7 disable clears
        wr(8'h10, 32'h0);
        rd(8'h1C, v); check("R7 disable", v, 0);
        wr(8'h10, 32'h4);
        idle(5);
        rd(8'h1C, v); check("R7 start without enable", v, 0);

        // R6 R9 one-shot, set-once shape
        setup_off(mk_setup(0, 0, 0, 1, 0, 0), 2, 5);
        wr(8'h10, 32'h3);
        idle(20);
        rd(8'h1C, v); check("R6 single stopped", v, 0);
        idle(10);
        rd(8'h1C, v); check("R6 single stays", v, 0);
        rd(8'h00, v); check("R6 wrap flag", v[1:0], 2'b11);
        check("R9 once held", 32'(wave_out), 1);
        wr(8'h10, 32'h3);
        check("R9 restart clears", 32'(wave_out), 0);
        idle(20);

        // R14 R13 interrupt mask and clear
        wr(8'h08, 32'h00);
        check("R14 masked", 32'(irq), 0);
        wr(8'h08, 32'h02);
        check("R14 irq on", 32'(irq), 1);
        wr(8'h04, 32'h02);
        rd(8'h00, v); check("R13 cleared bit", v[1], 0);
        check("R13 other kept", v[0], 1);
        check("R14 irq off", 32'(irq), 0);
        wr(8'h08, 32'h00);

        // R12 preload defers to wrap
        setup_off(mk_setup(0, 0, 0, 0, 0, 1), 10, 40);
        wr(8'h10, 32'h5);
        idle(5);
        wr(8'h04, 32'h1F);
        wr(8'h14, 32'd30);
        idle(3);
        rd(8'h14, v); check("R12 preload held", v, 10);
        rd(8'h00, v); check("R12 no done yet", v[3], 0);
        idle(50);
        rd(8'h14, v); check("R12 preload applied", v, 30);
        rd(8'h00, v); check("R12 done after wrap", v[3], 1);

        // R10 rising trigger
        setup_off(mk_setup(0, 0, 1, 0, 0, 0), 0, 500);
        wr(8'h10, 32'h3);
        idle(10);
        rd(8'h1C, v); check("R10 armed idle", v, 0);
        trig_in = 1'b1; idle(4); trig_in = 1'b0;
        idle(16);
        rd(8'h1C, v); check("R10 rise started", 32'(v > 0 && v < 40), 1);
        rd(8'h00, v); check("R10 trig flag", v[2], 1);

        // R10 falling-only trigger
        setup_off(mk_setup(0, 0, 2, 0, 0, 0), 0, 500);
        wr(8'h10, 32'h3);
        trig_in = 1'b1; idle(15);
        rd(8'h1C, v); check("R10 fall ignores rise", v, 0);
        rd(8'h00, v); check("R10 no flag on rise", v[2], 0);
        trig_in = 1'b0; idle(15);
        rd(8'h1C, v); check("R10 fall started", 32'(v > 0 && v < 40), 1);

        // R11 filter rejects short pulse
        setup_off(mk_setup(0, 3, 3, 0, 0, 0), 0, 500);
        wr(8'h10, 32'h5);
        trig_in = 1'b1; idle(3); trig_in = 1'b0;
        idle(20);
        rd(8'h00, v); check("R11 glitch flag", v[2], 0);
        rd(8'h1C, v); check("R11 glitch count", v, 0);
        trig_in = 1'b1; idle(12); trig_in = 1'b0;
        idle(20);
        rd(8'h00, v); check("R11 long pulse flag", v[2], 1);
        rd(8'h1C, v); check("R11 long pulse start", 32'(v > 0), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule